// File: doc/BRIEF.md
# Transactional Store Buffer with Atomic Commit

This block sits between a small in-order core and its data memory and gives the core hardware transactions. A begin command copies the core's architectural register file into a private snapshot register. While the transaction runs, every store lands in a small private write buffer and never reaches memory. Loads look in that buffer first, so the core always sees its own speculative writes.

An end command drains the buffer into memory. The drain runs one write per accepted cycle, and the core sees the whole set land as one atomic update. A conflict signalled from outside, a store that needs a buffer slot when none is left, or a second begin while a transaction is open all cancel the transaction. On a cancel the buffer is thrown away and the snapshot is driven back to the register file. A cause code is left in a status register that the rollback does not touch, so software can read the cause afterwards. Outside a transaction the core's loads and stores pass straight through to memory.

Top module: `tm_commit_unit`

## Requirements
- R1: A cycle with `tx_begin` high while idle stores `rf_snap` in the snapshot register. On an abort, `rf_restore` is high for exactly one cycle, one clock after the aborting cycle, and `rf_restore_data` then carries the value captured at begin, even if `rf_snap` has changed since.
- R2: While `tx_active` is high, no write reaches memory (`mem_we` stays 0), and the memory contents stay unchanged until commit.
- R3: A load while `tx_active` is high returns the buffered data for its address if that address is in the buffer. Otherwise it returns `mem_rdata` for the same address, in the same cycle.
- R4: The buffer holds 8 address/data entries. A store to an address already in the buffer overwrites that entry in place and takes no new slot, so the commit writes each distinct address exactly once.
- R5: `tx_end` with a non-empty buffer starts a commit. From the next cycle `busy` is high and `mem_we` is high, with entries written in order of their first insertion, one per cycle in which `mem_ready` is high. `busy` falls and `tx_done` pulses with `abort_code` = 0 one clock after the last write is accepted. With an empty buffer, `tx_done` pulses with code 0 one clock after `tx_end` and `busy` never rises.
- R6: `conflict_in` high while `tx_active` is high aborts the transaction. The next cycle shows `abort_code` = 1 and `tx_done` high, and the buffered stores are discarded and never written.
- R7: A store to a ninth distinct address while 8 entries are in use aborts with `abort_code` = 2.
- R8: `tx_begin` while `tx_active` is high aborts with `abort_code` = 3 and does not open a new transaction. Conflict (code 1) outranks a second begin (code 3), and a second begin outranks overflow (code 2).
- R9: While `busy` is high, `conflict_in` is ignored. The commit completes and no restore occurs.
- R10: `abort_code` changes only in a cycle where `tx_done` is high. A new begin does not clear it.
- R11: While idle, a store drives `mem_we` with the core's address and data, and a load returns `mem_rdata`. Core requests in the cycle of `tx_end` are ignored.
- R12: After synchronous reset the unit is idle, with `tx_active`, `busy`, `tx_done` and `rf_restore` low and `abort_code` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_begin | input | 1 | Open a transaction (single-cycle command) |
| tx_end | input | 1 | Close and commit the transaction |
| conflict_in | input | 1 | External data-conflict indication |
| core_req | input | 1 | Core load/store request valid |
| core_we | input | 1 | 1 = store, 0 = load |
| core_addr | input | AW (8) | Core address |
| core_wdata | input | DW (16) | Store data |
| core_rdata | output | DW (16) | Load data (combinational) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW (8) | Memory address |
| mem_wdata | output | DW (16) | Memory write data |
| mem_rdata | input | DW (16) | Memory read data (combinational) |
| mem_ready | input | 1 | Memory accepts the write this cycle |
| rf_snap | input | NREG*DW (64) | Current register-file contents |
| rf_restore | output | 1 | Load `rf_restore_data` into the register file |
| rf_restore_data | output | NREG*DW (64) | Snapshot taken at begin |
| tx_active | output | 1 | Transaction open, stores buffered |
| busy | output | 1 | Commit drain in progress |
| tx_done | output | 1 | One-cycle pulse when a transaction ends |
| abort_code | output | 2 | 0 commit, 1 conflict, 2 overflow, 3 nested begin |

## Verification
The assertions check, on every cycle, the rules that need no memory model. No memory write is issued while a transaction is open. `busy` implies a pending write. A conflict or a second begin during a transaction produces the matching code with a one-cycle restore pulse, and a conflict during the drain causes no restore. The code register moves only when `tx_done` is high. The bench scenarios cover the properties that depend on data. These are buffer hits versus misses on loads, in-place overwrite, commit order under memory back-pressure, and restore data that differs from the live register file. They also cover buffered stores that vanish on every kind of abort, and overflow detection at exactly the ninth distinct address.

// File: rtl/tm_pkg.sv
package tm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_COMMIT = 2'd2
    } tm_state_e;

    typedef enum logic [1:0] {
        CODE_COMMIT   = 2'd0,
        CODE_CONFLICT = 2'd1,
        CODE_OVERFLOW = 2'd2,
        CODE_NESTED   = 2'd3
    } tm_code_e;

    // Cause priority: conflict, then nested begin, then overflow.
    function automatic tm_code_e pick_cause(input logic conflict, input logic nested);
        if (conflict)    return CODE_CONFLICT;
        else if (nested) return CODE_NESTED;
        else             return CODE_OVERFLOW;
    endfunction

endpackage

// File: rtl/tm_wbuf.sv
module tm_wbuf #(
    parameter int DEPTH = 8,
    parameter int AW    = 8,
    parameter int DW    = 16,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          wr_en,
    input  logic [AW-1:0] key_addr,
    input  logic [DW-1:0] wr_data,
    output logic          hit,
    output logic [DW-1:0] hit_data,
    output logic [CW-1:0] count,
    input  logic [IW-1:0] rd_idx,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [AW-1:0]    ent_addr [DEPTH];
    logic [DW-1:0]    ent_data [DEPTH];
    logic [DEPTH-1:0] match;
    logic [IW-1:0]    hit_idx;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = (CW'(g) < count) && (ent_addr[g] == key_addr);
    end

    assign hit = |match;

    always_comb begin
        hit_idx  = '0;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit_idx  = IW'(i);
                hit_data = ent_data[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (wr_en) begin
            if (hit) begin
                ent_data[hit_idx] <= wr_data;
            end else if (count < CW'(DEPTH)) begin
                ent_addr[count[IW-1:0]] <= key_addr;
                ent_data[count[IW-1:0]] <= wr_data;
                count <= count + CW'(1);
            end
        end
    end

    assign rd_addr = ent_addr[rd_idx];
    assign rd_data = ent_data[rd_idx];

endmodule

// File: rtl/tm_snap.sv
module tm_snap #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)          q <= '0;
        else if (capture) q <= d;
    end
endmodule

// File: rtl/tm_ctrl.sv
module tm_ctrl
    import tm_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int IW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_begin,
    input  logic          tx_end,
    input  logic          conflict,
    input  logic          st_req,
    input  logic          buf_hit,
    input  logic [CW-1:0] buf_count,
    input  logic          mem_ready,
    output tm_state_e     state,
    output logic [IW-1:0] drain_idx,
    output logic          buf_clear,
    output logic          buf_wr,
    output logic          snap_capture,
    output logic          restore_pulse,
    output logic          done_pulse,
    output tm_code_e      code
);
    logic in_act, ovf, abort_now, last;

    always_comb begin
        in_act       = (state == ST_ACTIVE);
        ovf          = in_act && st_req && !tx_end && !buf_hit && (buf_count == CW'(DEPTH));
        abort_now    = in_act && (conflict || tx_begin || ovf);
        buf_wr       = in_act && st_req && !tx_end && !abort_now;
        snap_capture = (state == ST_IDLE) && tx_begin;
        buf_clear    = snap_capture || abort_now;
        last         = (CW'(drain_idx) + CW'(1)) == buf_count;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state         <= ST_IDLE;
            drain_idx     <= '0;
            restore_pulse <= 1'b0;
            done_pulse    <= 1'b0;
            code          <= CODE_COMMIT;
        end else begin
            restore_pulse <= 1'b0;
            done_pulse    <= 1'b0;
            unique case (state)
                ST_IDLE: if (tx_begin) state <= ST_ACTIVE;
                ST_ACTIVE: begin
                    if (abort_now) begin
                        code          <= pick_cause(conflict, tx_begin);
                        restore_pulse <= 1'b1;
                        done_pulse    <= 1'b1;
                        state         <= ST_IDLE;
                    end else if (tx_end) begin
                        if (buf_count == '0) begin
                            code       <= CODE_COMMIT;
                            done_pulse <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            drain_idx <= '0;
                            state     <= ST_COMMIT;
                        end
                    end
                end
                ST_COMMIT: begin
                    if (mem_ready) begin
                        if (last) begin
                            code       <= CODE_COMMIT;
                            done_pulse <= 1'b1;
                            state      <= ST_IDLE;
                        end else begin
                            drain_idx <= drain_idx + IW'(1);
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/tm_commit_unit.sv
module tm_commit_unit
    import tm_pkg::*;
#(
    parameter int AW    = 8,
    parameter int DW    = 16,
    parameter int NREG  = 4,
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tx_begin,
    input  logic               tx_end,
    input  logic               conflict_in,
    input  logic               core_req,
    input  logic               core_we,
    input  logic [AW-1:0]      core_addr,
    input  logic [DW-1:0]      core_wdata,
    output logic [DW-1:0]      core_rdata,
    output logic               mem_we,
    output logic [AW-1:0]      mem_addr,
    output logic [DW-1:0]      mem_wdata,
    input  logic [DW-1:0]      mem_rdata,
    input  logic               mem_ready,
    input  logic [NREG*DW-1:0] rf_snap,
    output logic               rf_restore,
    output logic [NREG*DW-1:0] rf_restore_data,
    output logic               tx_active,
    output logic               busy,
    output logic               tx_done,
    output logic [1:0]         abort_code
);
    localparam int SNAPW = NREG * DW;
    localparam int IW    = $clog2(DEPTH);
    localparam int CW    = $clog2(DEPTH + 1);

    tm_state_e     state;
    tm_code_e      code;
    logic [IW-1:0] drain_idx;
    logic [CW-1:0] buf_count;
    logic          buf_clear, buf_wr, buf_hit, snap_capture;
    logic [DW-1:0] hit_data, drain_data;
    logic [AW-1:0] drain_addr;

    tm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_end(tx_end),
        .conflict(conflict_in), .st_req(core_req && core_we),
        .buf_hit(buf_hit), .buf_count(buf_count), .mem_ready(mem_ready),
        .state(state), .drain_idx(drain_idx), .buf_clear(buf_clear),
        .buf_wr(buf_wr), .snap_capture(snap_capture),
        .restore_pulse(rf_restore), .done_pulse(tx_done), .code(code)
    );

    tm_wbuf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_wbuf (
        .clk(clk), .rst(rst), .clear(buf_clear), .wr_en(buf_wr),
        .key_addr(core_addr), .wr_data(core_wdata),
        .hit(buf_hit), .hit_data(hit_data), .count(buf_count),
        .rd_idx(drain_idx), .rd_addr(drain_addr), .rd_data(drain_data)
    );

    tm_snap #(.W(SNAPW)) u_snap (
        .clk(clk), .rst(rst), .capture(snap_capture),
        .d(rf_snap), .q(rf_restore_data)
    );

    always_comb begin
        tx_active = (state == ST_ACTIVE);
        busy      = (state == ST_COMMIT);
        if (busy) begin
            mem_we    = 1'b1;
            mem_addr  = drain_addr;
            mem_wdata = drain_data;
        end else begin
            mem_we    = (state == ST_IDLE) && core_req && core_we;
            mem_addr  = core_addr;
            mem_wdata = core_wdata;
        end
        core_rdata = (tx_active && buf_hit) ? hit_data : mem_rdata;
        abort_code = code;
    end
endmodule

// File: rtl/tm_commit_unit_chk.sv
module tm_commit_unit_chk (
    input logic       clk,
    input logic       rst,
    input logic       tx_begin,
    input logic       conflict_in,
    input logic       tx_active,
    input logic       busy,
    input logic       mem_we,
    input logic       rf_restore,
    input logic       tx_done,
    input logic [1:0] abort_code
);
    assert_no_mem_write_in_tx_R2: assert property (@(posedge clk) disable iff (rst)
        tx_active |-> !mem_we);

    assert_busy_drives_write_R5: assert property (@(posedge clk) disable iff (rst)
        busy |-> (mem_we && !tx_active));

    assert_commit_code_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (tx_done && !rf_restore) |-> (abort_code == 2'd0));

    assert_conflict_aborts_R6: assert property (@(posedge clk) disable iff (rst)
        (tx_active && conflict_in) |=> (rf_restore && tx_done && abort_code == 2'd1));

    assert_nested_begin_R8: assert property (@(posedge clk) disable iff (rst)
        (tx_active && tx_begin && !conflict_in) |=> (rf_restore && abort_code == 2'd3));

    assert_no_restore_in_drain_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !rf_restore);

    assert_code_moves_on_done_R10: assert property (@(posedge clk) disable iff (rst)
        !$stable(abort_code) |-> tx_done);

    assert_restore_single_R1: assert property (@(posedge clk) disable iff (rst)
        rf_restore |=> !rf_restore);
endmodule

bind tm_commit_unit tm_commit_unit_chk u_chk (
    .clk(clk), .rst(rst), .tx_begin(tx_begin), .conflict_in(conflict_in),
    .tx_active(tx_active), .busy(busy), .mem_we(mem_we),
    .rf_restore(rf_restore), .tx_done(tx_done), .abort_code(abort_code)
);

// File: tb/tm_commit_unit_bench.sv
`timescale 1ns/1ps
module tm_commit_unit_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_begin = 0, tx_end = 0, conflict_in = 0;
    logic        core_req = 0, core_we = 0;
    logic [7:0]  core_addr = '0;
    logic [15:0] core_wdata = '0, core_rdata;
    logic        mem_we, mem_ready = 1'b1;
    logic [7:0]  mem_addr;
    logic [15:0] mem_wdata, mem_rdata;
    logic [63:0] rf_snap = '0, rf_restore_data;
    logic        rf_restore, tx_active, busy, tx_done;
    logic [1:0]  abort_code;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    tm_commit_unit u_tm_commit_unit (
        .clk(clk), .rst(rst), .tx_begin(tx_begin), .tx_end(tx_end),
        .conflict_in(conflict_in), .core_req(core_req), .core_we(core_we),
        .core_addr(core_addr), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .rf_snap(rf_snap),
        .rf_restore(rf_restore), .rf_restore_data(rf_restore_data),
        .tx_active(tx_active), .busy(busy), .tx_done(tx_done),
        .abort_code(abort_code)
    );

    // Memory model with a log of drain-time writes
    logic [15:0] mem [256];
    logic [7:0]  wlog [8];
    int          wr_cnt;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= '0;
            wr_cnt <= 0;
        end else if (mem_we && mem_ready) begin
            mem[mem_addr] <= mem_wdata;
            if (busy) begin
                wlog[wr_cnt[2:0]] <= mem_addr;
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    // {is_store, addr, data-or-expected}
    localparam logic [24:0] DIRECT_TBL [6] = '{
        {1'b1, 8'h10, 16'h1111},
        {1'b1, 8'h20, 16'h2222},
        {1'b0, 8'h10, 16'h1111},
        {1'b1, 8'h10, 16'h3333},
        {1'b0, 8'h10, 16'h3333},
        {1'b0, 8'h20, 16'h2222}
    };

    localparam logic [63:0] SNAP_A = 64'h0A0A_1111_2222_3333;
    localparam logic [63:0] SNAP_B = 64'h0B0B_4444_5555_6666;
    localparam logic [63:0] SNAP_C = 64'h0C0C_7777_8888_9999;
    localparam logic [63:0] SNAP_D = 64'h0D0D_AAAA_BBBB_CCCC;
    localparam logic [63:0] SNAP_E = 64'h0E0E_DDDD_EEEE_FFFF;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic store(input logic [7:0] a, input logic [15:0] d);
        core_req = 1; core_we = 1; core_addr = a; core_wdata = d;
        #1;
        if (tx_active) chk("R2 no write while active", mem_we, 0);
        else           chk("R11 direct write strobe", mem_we, 1);
        @(negedge clk);
        core_req = 0; core_we = 0;
    endtask

    task automatic load_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        core_req = 1; core_we = 0; core_addr = a;
        #1 chk(req, core_rdata, exp);
        @(negedge clk);
        core_req = 0;
    endtask

    task automatic do_begin(input logic [63:0] s);
        rf_snap = s; tx_begin = 1;
        @(negedge clk);
        tx_begin = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int wc0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk("R12 tx_active", tx_active, 0);
        chk("R12 busy", busy, 0);
        chk("R12 code", abort_code, 0);
        chk("R12 restore", rf_restore, 0);

        // R11: direct traffic from table
        for (int i = 0; i < 6; i++) begin
            if (DIRECT_TBL[i][24]) store(DIRECT_TBL[i][23:16], DIRECT_TBL[i][15:0]);
            else load_chk("R11 direct load", DIRECT_TBL[i][23:16], DIRECT_TBL[i][15:0]);
        end

        // Commit path
        do_begin(SNAP_A);
        chk("R1 begin opens transaction", tx_active, 1);
        store(8'h30, 16'hAAAA);
        store(8'h40, 16'hBBBB);
        store(8'h30, 16'hCCCC);
        load_chk("R3 buffer hit", 8'h30, 16'hCCCC);
        load_chk("R3 buffer miss", 8'h10, 16'h3333);
        chk("R2 memory untouched", mem[8'h30], 0);
        wc0 = wr_cnt;
        mem_ready = 0;
        tx_end = 1;
        @(negedge clk);
        tx_end = 0;
        chk("R5 busy after end", busy, 1);
        conflict_in = 1;
        for (int k = 0; k < 20 && busy; k++) begin
            mem_ready = (k != 0);
            @(negedge clk);
            chk("R9 no restore during drain", rf_restore, 0);
        end
        conflict_in = 0;
        mem_ready = 1;
        chk("R5 busy released", busy, 0);
        chk("R5 done pulse", tx_done, 1);
        chk("R5 commit code", abort_code, 0);
        chk("R4 one write per address", wr_cnt - wc0, 2);
        chk("R5 first drained address", wlog[wc0[2:0]], 8'h30);
        chk("R4 newest value committed", mem[8'h30], 16'hCCCC);
        chk("R5 second entry committed", mem[8'h40], 16'hBBBB);

        // Conflict abort
        do_begin(SNAP_B);
        store(8'h50, 16'h1234);
        rf_snap = SNAP_E;
        conflict_in = 1;
        @(negedge clk);
        conflict_in = 0;
        chk("R1 restore pulse", rf_restore, 1);
        chk("R1 restore data", rf_restore_data, SNAP_B);
        chk("R6 conflict code", abort_code, 1);
        chk("R6 transaction closed", tx_active, 0);
        @(negedge clk);
        chk("R1 restore single cycle", rf_restore, 0);
        chk("R10 code held", abort_code, 1);
        load_chk("R6 store discarded", 8'h50, 16'h0000);

        // Overflow abort
        do_begin(SNAP_C);
        chk("R10 begin keeps code", abort_code, 1);
        for (int i = 0; i < 8; i++) store(8'h60 + 8'(i), 16'(i + 1));
        store(8'h60, 16'hFFFF);
        chk("R4 overwrite when full keeps running", tx_active, 1);
        store(8'h68, 16'h0009);
        chk("R7 overflow code", abort_code, 2);
        chk("R7 restore", rf_restore, 1);
        chk("R7 nothing written", mem[8'h60], 0);

        // Nested begin abort
        do_begin(SNAP_D);
        store(8'h70, 16'h0005);
        do_begin(SNAP_E);
        chk("R8 nested code", abort_code, 3);
        chk("R8 restore data first snapshot", rf_restore_data, SNAP_D);
        chk("R8 no new transaction", tx_active, 0);
        chk("R8 store discarded", mem[8'h70], 0);

        // Empty commit
        do_begin(SNAP_A);
        tx_end = 1;
        @(negedge clk);
        tx_end = 0;
        chk("R5 empty commit done", tx_done, 1);
        chk("R5 empty commit code", abort_code, 0);
        chk("R5 empty commit not busy", busy, 0);
        chk("R5 empty commit closed", tx_active, 0);

        report();
    end
endmodule